// File: doc/BRIEF.md
# Buffered SPI Master Peripheral

This block is a memory-mapped SPI master. Software places bytes in a transmit queue through a register port. A shift engine sends each byte on MOSI, most significant bit first. For every byte it sends, it captures one byte from MISO into a receive queue, so every transfer is full duplex. The SCK rate is fixed when the block is built: each SCK half period lasts `SCK_HALF` clock cycles. Clock polarity and phase are chosen in the control word. Device selects are active-low outputs that software loads as a one-hot-low pattern.

A typical driver sets the hold bit and preloads the transmit queue. It then clears the hold bit to start shifting, and waits for the transmit-drained interrupt. When that interrupt arrives, it collects the received bytes and refills the queue. The interrupt logic has one sticky status bit per event. Each bit has its own enable, all of them pass through a global enable, and software clears a status bit by writing a one to it. Writing a key value to the reset register returns the whole block to its reset state.

The register bus is a single-cycle port. Writes are strobed, and read data is combinational. A read of the receive-data address removes the byte it returns. The register word addresses are: control 0, status 1, transmit data 2, receive data 3, select 4, soft reset 5, global interrupt enable 6, interrupt status 7, interrupt enable 8.

Top module: `spim_periph`

## Requirements
- R1: After reset, the control word reads 0 and the select register reads all ones. Status reads 0x05 (receive empty and transmit idle). The interrupt status and both interrupt enables read 0, `irq` is low and `sck` is low.
- R2: Each transfer is 8 bits, most significant bit first. Consecutive sampling edges are exactly 2*`SCK_HALF` clock cycles apart.
- R3: Control bit 3 (CPOL) sets the idle level of `sck`. Control bit 4 (CPHA) chooses the sampling edge: the leading edge when CPHA is 0, the trailing edge when CPHA is 1. Each byte takes exactly 16 `sck` edges.
- R4: Every byte shifted out pushes the byte captured from `miso` into the receive queue. Reading address 3 returns the oldest byte and removes it. Reading it while the queue is empty returns 0.
- R5: A byte starts only when control bit 1 (enable) and bit 2 (master) are both 1 and bit 8 (hold) is 0. While the hold bit is set, no shifting begins even when the queue holds data. Clearing the hold bit starts the queued bytes.
- R6: The status word holds: bit0 receive empty, bit1 receive full, bit2 transmit queue empty with the shifter idle, bit3 transmit full, bit4 mode fault (always 0).
- R7: A write to a full transmit queue is dropped and sets interrupt status bit 3.
- R8: Interrupt status bit 4 sets when a received byte fills the receive queue. A byte that arrives while the queue is full is dropped and sets interrupt status bit 5.
- R9: Interrupt status bit 2 sets when a byte finishes shifting and the transmit queue is empty.
- R10: Writing ones to the interrupt status register clears those bits. `irq` is high exactly when bit 31 of the global enable is 1 and some status bit is set together with its enable bit.
- R11: The select register resets to all ones and reads back what was written. When control bit 7 (manual select) is set, `ss_n` always shows the register. When it is clear, `ss_n` shows the register only while a byte is shifting, and all ones otherwise.
- R12: Writing 0x0A to the soft-reset register (address 5) restores the full reset state, including both queues. Writing any other value has no effect.
- R13: Writing a one to control bit 5 empties the transmit queue, and writing a one to bit 6 empties the receive queue. Neither bit is stored, so both always read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | NSS | Active-low device selects |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `FIFO_DEPTH`=4, `SCK_HALF`=2 and `NSS`=4. With these values a few writes fill either queue, so the dropped-write, fill and overrun events are easy to reach. The short SCK period lets the bench send all 256 byte values, cycling through the four clock modes and inverting the loopback for the upper half of the range. For each byte it checks the received value, the bit order on MOSI, the SCK edge count and the spacing of the sampling edges.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int BYTE_W = 8;
  localparam int REG_AW = 4;
  localparam int IRQ_W  = 6;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL  = 4'd0,
    RA_STAT  = 4'd1,
    RA_TXD   = 4'd2,
    RA_RXD   = 4'd3,
    RA_SEL   = 4'd4,
    RA_SRST  = 4'd5,
    RA_GIE   = 4'd6,
    RA_ISTAT = 4'd7,
    RA_IEN   = 4'd8
  } reg_addr_e;

  // control word bit positions
  localparam int CB_EN     = 1;
  localparam int CB_MASTER = 2;
  localparam int CB_CPOL   = 3;
  localparam int CB_CPHA   = 4;
  localparam int CB_TXRST  = 5;
  localparam int CB_RXRST  = 6;
  localparam int CB_MANSS  = 7;
  localparam int CB_HOLD   = 8;
  localparam int CTRL_W    = 9;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 9'h19E;

  // interrupt status bit positions
  localparam int IB_TXDONE = 2;
  localparam int IB_TXDROP = 3;
  localparam int IB_RXFILL = 4;
  localparam int IB_RXOVR  = 5;

  localparam int GIE_BIT = 31;
  localparam logic [7:0] SRST_KEY = 8'h0A;

  function automatic logic irq_level(input logic gie, input logic [IRQ_W-1:0] st,
                                     input logic [IRQ_W-1:0] en);
    return gie & (|(st & en));
  endfunction

  // leading edges are even-numbered (0,2,..); CPHA=0 samples on them
  function automatic logic is_sample_edge(input logic leading, input logic cpha);
    return leading ^ cpha;
  endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   push,
  input  logic [W-1:0]           din,
  input  logic                   pop,
  output logic [W-1:0]           dout,
  output logic                   empty,
  output logic                   full,
  output logic [$clog2(DEPTH):0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH) + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rp];
  assign count   = cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
#(
  parameter int HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              start,
  input  logic [BYTE_W-1:0] din,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] dout,
  output logic              sck,
  output logic              mosi
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic              busy_q, phase_q, mosi_q, tick;
  logic [CW-1:0]     cnt_q;
  logic [3:0]        edge_q;
  logic [BYTE_W-1:0] tx_sh, rx_sh;

  assign tick = (cnt_q == CW'(HALF - 1));
  assign busy = busy_q;
  assign done = busy_q & tick & (edge_q == 4'hF);
  assign dout = cpha ? {rx_sh[BYTE_W-2:0], miso} : rx_sh;
  assign sck  = cpol ^ phase_q;
  assign mosi = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; phase_q <= 1'b0; mosi_q <= 1'b0;
      cnt_q <= '0; edge_q <= '0; tx_sh <= '0; rx_sh <= '0;
    end else if (clr) begin
      busy_q <= 1'b0; phase_q <= 1'b0; mosi_q <= 1'b0;
      cnt_q <= '0; edge_q <= '0; tx_sh <= '0; rx_sh <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        edge_q  <= '0;
        phase_q <= 1'b0;
        if (!cpha) begin
          mosi_q <= din[BYTE_W-1];
          tx_sh  <= {din[BYTE_W-2:0], 1'b0};
        end else begin
          tx_sh  <= din;
        end
      end
    end else if (tick) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
      if (is_sample_edge(~edge_q[0], cpha)) begin
        rx_sh <= {rx_sh[BYTE_W-2:0], miso};
      end else begin
        mosi_q <= tx_sh[BYTE_W-1];
        tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
      if (edge_q == 4'hF) busy_q <= 1'b0;
      edge_q <= edge_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spim_periph.sv
module spim_periph
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int SCK_HALF   = 4,
  parameter int NSS        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [NSS-1:0]    ss_n,
  output logic              irq
);
  localparam int FCW = $clog2(FIFO_DEPTH) + 1;
  localparam logic [NSS-1:0] SS_IDLE = '1;

  logic acc_wr, acc_rd, soft_rst, ctrl_wr, tx_wr, rx_rd, istat_wr;
  logic tx_flush, rx_flush;
  logic [CTRL_W-1:0] ctrl_q;
  logic [NSS-1:0]    ss_q;
  logic              gie_q;
  logic [IRQ_W-1:0]  ien_q, istat_q, ev;

  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [FCW-1:0]    tx_cnt, rx_cnt;
  logic [BYTE_W-1:0] tx_head, rx_head, sh_rx_byte;
  logic              sh_start, sh_busy, sh_done;
  logic              ctrl_cpol, ctrl_cpha, ctrl_hold, ctrl_manual;
  logic              tx_idle;
  logic              ss_all_high;

  assign acc_wr   = bus_en & bus_we;
  assign acc_rd   = bus_en & ~bus_we;
  assign soft_rst = acc_wr && (bus_addr == RA_SRST) && (bus_wdata[7:0] == SRST_KEY);
  assign ctrl_wr  = acc_wr && (bus_addr == RA_CTRL);
  assign tx_wr    = acc_wr && (bus_addr == RA_TXD);
  assign istat_wr = acc_wr && (bus_addr == RA_ISTAT);
  assign rx_rd    = acc_rd && (bus_addr == RA_RXD);
  assign tx_flush = soft_rst | (ctrl_wr & bus_wdata[CB_TXRST]);
  assign rx_flush = soft_rst | (ctrl_wr & bus_wdata[CB_RXRST]);

  assign ctrl_cpol   = ctrl_q[CB_CPOL];
  assign ctrl_cpha   = ctrl_q[CB_CPHA];
  assign ctrl_hold   = ctrl_q[CB_HOLD];
  assign ctrl_manual = ctrl_q[CB_MANSS];

  assign sh_start = ctrl_q[CB_EN] & ctrl_q[CB_MASTER] & ~ctrl_hold &
                    ~tx_empty & ~sh_busy & ~tx_flush;

  spim_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_wr), .din(bus_wdata[BYTE_W-1:0]), .pop(sh_start),
    .dout(tx_head), .empty(tx_empty), .full(tx_full), .count(tx_cnt)
  );

  spim_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(sh_done), .din(sh_rx_byte), .pop(rx_rd),
    .dout(rx_head), .empty(rx_empty), .full(rx_full), .count(rx_cnt)
  );

  spim_shift #(.HALF(SCK_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst),
    .cpol(ctrl_cpol), .cpha(ctrl_cpha),
    .start(sh_start), .din(tx_head), .miso(miso),
    .busy(sh_busy), .done(sh_done), .dout(sh_rx_byte),
    .sck(sck), .mosi(mosi)
  );

  // interrupt events
  always_comb begin
    ev            = '0;
    ev[IB_TXDONE] = sh_done & tx_empty;
    ev[IB_TXDROP] = tx_wr & tx_full;
    ev[IB_RXFILL] = sh_done & ~rx_full & ~rx_rd & (rx_cnt == FCW'(FIFO_DEPTH - 1));
    ev[IB_RXOVR]  = sh_done & rx_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; ss_q <= SS_IDLE; gie_q <= 1'b0; ien_q <= '0; istat_q <= '0;
    end else if (soft_rst) begin
      ctrl_q <= '0; ss_q <= SS_IDLE; gie_q <= 1'b0; ien_q <= '0; istat_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata[CTRL_W-1:0] & CTRL_KEEP;
      if (acc_wr && bus_addr == RA_SEL) ss_q <= bus_wdata[NSS-1:0];
      if (acc_wr && bus_addr == RA_GIE) gie_q <= bus_wdata[GIE_BIT];
      if (acc_wr && bus_addr == RA_IEN) ien_q <= bus_wdata[IRQ_W-1:0];
      istat_q <= (istat_q & ~(istat_wr ? bus_wdata[IRQ_W-1:0] : '0)) | ev;
    end
  end

  assign tx_idle     = tx_empty & ~sh_busy;
  assign ss_n        = (ctrl_manual | sh_busy) ? ss_q : SS_IDLE;
  assign irq         = irq_level(gie_q, istat_q, ien_q);
  assign ss_all_high = &ss_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_q;
      RA_STAT:  bus_rdata[4:0] = {1'b0, tx_full, tx_idle, rx_full, rx_empty};
      RA_RXD:   bus_rdata[BYTE_W-1:0] = rx_empty ? '0 : rx_head;
      RA_SEL:   bus_rdata[NSS-1:0] = ss_q;
      RA_GIE:   bus_rdata[GIE_BIT] = gie_q;
      RA_ISTAT: bus_rdata[IRQ_W-1:0] = istat_q;
      RA_IEN:   bus_rdata[IRQ_W-1:0] = ien_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spim_periph_chk.sv
module spim_periph_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       irq,
  input logic       ctrl_cpol,
  input logic       ctrl_hold,
  input logic       sh_busy,
  input logic       sh_done,
  input logic       soft_rst,
  input logic       rx_flush,
  input logic       tx_wr,
  input logic       tx_full,
  input logic       tx_empty,
  input logic       rx_full,
  input logic       rx_empty,
  input logic [8:0] ctrl_q,
  input logic [5:0] istat_q,
  input logic       ss_all_high
);
  a_r3_sck_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_busy |-> (sck == ctrl_cpol));

  a_r5_hold_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_hold && !sh_busy) |=> !sh_busy);

  a_r4_rx_gets_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_done && !rx_full && !soft_rst && !rx_flush) |=> !rx_empty);

  a_r7_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_full) |=> istat_q[3]);

  a_r12_soft_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ctrl_q == 9'h000 && ss_all_high && tx_empty && rx_empty && !irq && !sh_busy));
endmodule

bind spim_periph spim_periph_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .irq(irq),
  .ctrl_cpol(ctrl_cpol), .ctrl_hold(ctrl_hold),
  .sh_busy(sh_busy), .sh_done(sh_done), .soft_rst(soft_rst), .rx_flush(rx_flush),
  .tx_wr(tx_wr), .tx_full(tx_full), .tx_empty(tx_empty),
  .rx_full(rx_full), .rx_empty(rx_empty),
  .ctrl_q(ctrl_q), .istat_q(istat_q), .ss_all_high(ss_all_high)
);

// File: tb/spim_periph_tb.sv
`timescale 1ns/1ps
module spim_periph_tb;
  import spim_pkg::*;

  localparam int DEPTH = 4;
  localparam int HALF  = 2;
  localparam int NSS   = 4;
  localparam int TCLK  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic miso, sck, mosi, irq;
  logic [NSS-1:0] ss_n;
  logic loop_inv = 1'b0;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #(TCLK/2) clk = ~clk;
  assign miso = loop_inv ? ~mosi : mosi;

  spim_periph #(.FIFO_DEPTH(DEPTH), .SCK_HALF(HALF), .NSS(NSS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .miso(miso), .sck(sck), .mosi(mosi), .ss_n(ss_n), .irq(irq)
  );

  // line monitor: sampling edge is rising when CPOL==CPHA
  logic cur_cpol = 1'b0, cur_cpha = 1'b0;
  logic [7:0] mon = '0;
  int medges = 0, msamp = 0;
  time t_first = 0, t_last = 0;
  always @(posedge sck or negedge sck) begin
    medges = medges + 1;
    if (sck == (cur_cpol == cur_cpha)) begin
      mon = {mon[6:0], mosi};
      if (msamp == 0) t_first = $time;
      t_last = $time;
      msamp = msamp + 1;
    end
  end

  task automatic mon_clear();
    medges = 0; msamp = 0; mon = '0;
  endtask

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int k;
    s = '0; k = 0;
    while (!s[2] && k < 2000) begin
      rd(RA_STAT, s);
      k++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0] expb;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(RA_CTRL, r);  check(r == 0, "R1 ctrl", r, 0);
    rd(RA_STAT, r);  check(r == 32'h5, "R1 R6 status", r, 5);
    rd(RA_SEL, r);   check(r == 32'hF, "R1 select", r, 32'hF);
    rd(RA_ISTAT, r); check(r == 0, "R1 istat", r, 0);
    rd(RA_IEN, r);   check(r == 0, "R1 ien", r, 0);
    rd(RA_GIE, r);   check(r == 0, "R1 gie", r, 0);
    check(irq == 0 && sck == 0, "R1 irq/sck", {irq, sck}, 0);
    rd(RA_RXD, r);   check(r == 0, "R4 empty read", r, 0);

    // R5 hold, R11 manual select
    wr(RA_IEN, 32'h4);
    wr(RA_GIE, 32'h8000_0000);
    wr(RA_CTRL, 32'h186);
    wr(RA_SEL, 32'hD);
    check(ss_n == 4'hD, "R11 manual select", ss_n, 4'hD);
    mon_clear();
    wr(RA_TXD, 32'hA5);
    repeat (40) @(negedge clk);
    rd(RA_STAT, r); check(r == 32'h1, "R5 R6 held status", r, 1);
    check(medges == 0, "R5 no sck while held", medges, 0);
    wr(RA_CTRL, 32'h086);
    wait_idle();
    rd(RA_RXD, r); check(r[7:0] == 8'hA5, "R5 R4 release", r, 8'hA5);

    // R2 R3 R4 sweep over all byte values and modes
    for (int b = 0; b < 256; b++) begin
      logic [1:0] m;
      m = 2'(b % 4);
      cur_cpol = m[0]; cur_cpha = m[1];
      wr(RA_CTRL, 32'h086 | (32'(m[0]) << 3) | (32'(m[1]) << 4));
      check(sck == m[0], "R3 idle level", sck, m[0]);
      mon_clear();
      loop_inv = (b >= 128);
      wr(RA_TXD, 32'(b));
      wait_idle();
      expb = loop_inv ? ~8'(b) : 8'(b);
      rd(RA_RXD, r);
      check(r[7:0] == expb, "R4 duplex byte", r, expb);
      check(mon == 8'(b), "R2 msb-first", mon, b);
      check(medges == 16, "R3 edge count", medges, 16);
      check((t_last - t_first) == 7*2*HALF*TCLK, "R2 sample spacing", t_last - t_first, 7*2*HALF*TCLK);
    end
    loop_inv = 1'b0; cur_cpol = 0; cur_cpha = 0;
    wr(RA_CTRL, 32'h086);

    // R9 R10 interrupts
    check(irq == 1, "R9 irq", irq, 1);
    rd(RA_ISTAT, r); check(r == 32'h4, "R9 tx-done flag", r, 4);
    wr(RA_ISTAT, 32'h0);
    rd(RA_ISTAT, r); check(r == 32'h4, "R10 zero write keeps", r, 4);
    wr(RA_ISTAT, 32'h4);
    rd(RA_ISTAT, r); check(r == 0, "R10 w1c", r, 0);
    check(irq == 0, "R10 irq cleared", irq, 0);
    wr(RA_TXD, 32'h5A); wait_idle(); rd(RA_RXD, r);
    wr(RA_GIE, 32'h0);
    check(irq == 0, "R10 global gate", irq, 0);
    wr(RA_GIE, 32'h8000_0000);
    check(irq == 1, "R10 global on", irq, 1);
    wr(RA_IEN, 32'h0);
    check(irq == 0, "R10 source gate", irq, 0);
    wr(RA_ISTAT, 32'h3F);

    // R7 dropped write, R13 tx flush
    wr(RA_CTRL, 32'h186);
    for (int i = 0; i < 5; i++) wr(RA_TXD, 32'(i + 1));
    rd(RA_STAT, r);  check(r == 32'h9, "R7 R6 tx full", r, 9);
    rd(RA_ISTAT, r); check(r == 32'h8, "R7 drop flag", r, 8);
    wr(RA_CTRL, 32'h1A6);
    rd(RA_CTRL, r);  check(r == 32'h186, "R13 self-clear", r, 32'h186);
    rd(RA_STAT, r);  check(r == 32'h5, "R13 tx flushed", r, 5);
    wr(RA_ISTAT, 32'h3F);

    // R8 fill and overrun
    for (int i = 0; i < 4; i++) wr(RA_TXD, 32'h10 + 32'(i));
    wr(RA_CTRL, 32'h086);
    wait_idle();
    rd(RA_STAT, r);  check(r == 32'h6, "R8 R6 rx full", r, 6);
    rd(RA_ISTAT, r); check(r == 32'h14, "R8 fill flag", r, 32'h14);
    wr(RA_TXD, 32'h77);
    wait_idle();
    rd(RA_ISTAT, r); check(r == 32'h34, "R8 overrun flag", r, 32'h34);
    for (int i = 0; i < 4; i++) begin
      rd(RA_RXD, r);
      check(r[7:0] == 8'(8'h10 + i), "R8 kept bytes", r, 8'h10 + i);
    end
    rd(RA_STAT, r); check(r == 32'h5, "R8 drained", r, 5);
    wr(RA_TXD, 32'h66); wait_idle();
    wr(RA_CTRL, 32'h0C6);
    rd(RA_STAT, r); check(r == 32'h5, "R13 rx flushed", r, 5);

    // R12 soft reset
    wr(RA_CTRL, 32'h186);
    wr(RA_SRST, 32'h05);
    rd(RA_CTRL, r); check(r == 32'h186, "R12 wrong key ignored", r, 32'h186);
    wr(RA_TXD, 32'h42);
    wr(RA_SRST, 32'h0A);
    rd(RA_CTRL, r);  check(r == 0, "R12 ctrl", r, 0);
    rd(RA_SEL, r);   check(r == 32'hF, "R12 select", r, 32'hF);
    rd(RA_ISTAT, r); check(r == 0, "R12 istat", r, 0);
    rd(RA_GIE, r);   check(r == 0, "R12 gie", r, 0);
    rd(RA_STAT, r);  check(r == 32'h5, "R12 queues empty", r, 5);

    // R5 enable gating, R11 automatic select
    wr(RA_SEL, 32'hB);
    wr(RA_TXD, 32'h3C);
    repeat (40) @(negedge clk);
    rd(RA_STAT, r); check(r == 32'h1, "R5 disabled no shift", r, 1);
    check(ss_n == 4'hF, "R11 auto idle", ss_n, 4'hF);
    wr(RA_CTRL, 32'h006);
    repeat (4) @(negedge clk);
    check(ss_n == 4'hB, "R11 auto active", ss_n, 4'hB);
    wait_idle();
    check(ss_n == 4'hF, "R11 auto released", ss_n, 4'hF);
    rd(RA_RXD, r); check(r[7:0] == 8'h3C, "R5 R4 enabled byte", r, 8'h3C);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nfail, nchk);
    $finish;
  end
endmodule